// File: doc/BRIEF.md
# Multi-channel packet word packer

This block takes a narrow packet stream in which words from several channels are interleaved, one word per clock. Each word is either a control word or a 16-bit data word. A payload control word chooses the channel that owns the data words after it. It can also open a packet on that channel, and it can close the packet on the channel that was active before it. The block keeps a separate partial wide word for every channel and packs that channel's data words into it. When a wide word is complete, or when a packet ends, the block sends the wide word out. Each output word carries the channel index, packet start and end flags, an abort flag and a code that gives the number of valid bytes in it.

Alongside the packing, the block checks how far apart packet-start control words are. A start that comes too soon after the previous one raises a one-cycle bus-error flag. The data is still packed and sent as usual. Control words that select a channel without starting a packet can follow each other as closely as every second word without raising the flag.

Top module: `pkt_word_packer`

## Requirements
- R1: After reset every channel's partial word is empty and no start is pending, and out_valid and out_buserr are 0. A packet end on an empty channel straight after reset produces no output word.
- R2: A control word has in_ctl=1 and uses this layout:
  - bit 15: 1 for payload, 0 for idle.
  - bits 14:13: end status. 00 means none, 01 means abort, 10 means end with both bytes of the last word valid, and 11 means end with only the upper byte valid.
  - bit 12: packet start.
  - bits 4 and up: channel index, of which the low log2(NUM_CH) bits are used.
  
  A payload control word makes its channel the target of the data words that follow it.
- R3: Data words fill the target channel's wide word in order, with the first word in bits 63:48. A complete wide word is sent when the next data word for that channel arrives, or when that channel's packet ends. Every output appears on the clock edge that registers the word causing it, and out_mod is 000 on a word that does not end a packet.
- R4: Each channel keeps its partial word and its pending start while other channels' data is interleaved.
- R5: An end status other than 00 sends out the active channel's held words with out_eop=1. This happens even if the wide word is short. Unused slots read zero.
- R6: On a packet-ending word, out_mod is the valid byte count modulo 8: 2 bytes gives 010, 4 gives 100, 6 gives 110 and 8 gives 000. With end status 11 the count is one less.
- R7: out_sop is set on the first output word of a packet. A packet that fits in one output word has out_sop and out_eop set together.
- R8: A single payload control word can end the packet on the previously active channel and start a packet on the channel it names.
- R9: End status 01 sends the held words with out_eop=1 and out_abort=1.
- R10: An idle control word does not change the target channel and ignores its start bit. It produces output only when it carries an end status.
- R11: A payload control word with the start bit set, arriving fewer than MIN_SOP_GAP valid words after the previous one (default 8), sets out_buserr for one cycle. It is still acted on as normal.
- R12: A payload control word with no start bit never raises out_buserr, even when such words come back to back with single data words between them.
- R13: An end status on a channel with no held words produces no output word. It clears that channel's pending start.
- R14: A cycle with in_valid=0 changes no state and produces no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word present this cycle |
| in_ctl | input | 1 | 1 for a control word, 0 for a data word |
| in_word | input | 16 | Control or data word |
| out_valid | output | 1 | Output bundle valid |
| out_data | output | 16*SLOTS | Packed wide word, first input word in the top slot |
| out_chan | output | log2(NUM_CH) | Channel of the output word |
| out_sop | output | 1 | First output word of a packet |
| out_eop | output | 1 | Last output word of a packet |
| out_mod | output | log2(2*SLOTS) | Valid byte count modulo the word size on packet end |
| out_abort | output | 1 | Packet ended by abort |
| out_buserr | output | 1 | Packet-start spacing violation |

## Verification
A single payload control word can do three things in the same cycle. It can close the previous channel's packet and send that channel's short word, it can mark a packet start on a different channel, and it can trip the spacing check. The bench builds such words in three ways: one lands exactly MIN_SOP_GAP words after the previous start (no error), one lands a word sooner (error), and one lands only a few words after the previous start. A queue-based model predicts the whole output bundle and the error flag for every cycle, and the bench compares them one edge after the word is driven. This confirms that the flushed word, its flags and the error come out together, while the new channel's start shows up only on its own first output word.

// File: rtl/pkt_pack_pkg.sv
`timescale 1ns/1ps
package pkt_pack_pkg;

   localparam int WORD_W   = 16;
   localparam int ADDR_LSB = 4;
   localparam int ADDR_W   = 8;

   typedef enum logic [1:0] {
      END_NONE  = 2'b00,
      END_ABORT = 2'b01,
      END_TWO   = 2'b10,
      END_ONE   = 2'b11
   } end_kind_e;

   typedef struct packed {
      logic      payload;
      end_kind_e end_kind;
      logic      sop;
   } ctl_hdr_t;

   function automatic ctl_hdr_t split_hdr(input logic [WORD_W-1:0] w);
      ctl_hdr_t h;
      h.payload  = w[15];
      h.end_kind = end_kind_e'(w[14:13]);
      h.sop      = w[12];
      return h;
   endfunction

endpackage

// File: rtl/pkt_lane_store.sv
`timescale 1ns/1ps
module pkt_lane_store
   import pkt_pack_pkg::*;
#(
   parameter int NUM_CH    = 4,
   parameter int SLOTS     = 4,
   parameter bit MSB_FIRST = 1'b1
)(
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [$clog2(NUM_CH)-1:0]     sel_ch,
   input  logic                          data_en,
   input  logic [WORD_W-1:0]             word,
   input  logic                          clear_en,
   input  logic                          sop_en,
   input  logic [$clog2(NUM_CH)-1:0]     sop_ch,
   output logic [WORD_W*SLOTS-1:0]       sel_data,
   output logic [$clog2(SLOTS)-1:0]      sel_fill,
   output logic                          sel_full,
   output logic                          sel_sop
);

   localparam int CH_W   = $clog2(NUM_CH);
   localparam int FILL_W = $clog2(SLOTS);
   localparam int OUT_W  = WORD_W * SLOTS;

   logic [OUT_W-1:0]  placed_fill, placed_zero;
   logic [OUT_W-1:0]  data_arr [NUM_CH];
   logic [FILL_W-1:0] fill_arr [NUM_CH];
   logic              full_arr [NUM_CH];
   logic              sop_arr  [NUM_CH];

   if (MSB_FIRST) begin : g_msb_first
      always_comb begin
         placed_fill = '0;
         placed_fill[(SLOTS-1-int'(sel_fill))*WORD_W +: WORD_W] = word;
         placed_zero = '0;
         placed_zero[OUT_W-1 -: WORD_W] = word;
      end
   end else begin : g_lsb_first
      always_comb begin
         placed_fill = '0;
         placed_fill[int'(sel_fill)*WORD_W +: WORD_W] = word;
         placed_zero = '0;
         placed_zero[WORD_W-1:0] = word;
      end
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
      logic [OUT_W-1:0]  data_q, data_d;
      logic [FILL_W-1:0] fill_q, fill_d;
      logic              full_q, full_d, sop_q, sop_d;
      logic              hit;

      assign hit = (sel_ch == CH_W'(c));

      always_comb begin
         data_d = data_q;
         fill_d = fill_q;
         full_d = full_q;
         sop_d  = sop_q;
         if (data_en && hit) begin
            if (full_q) begin
               data_d = placed_zero;
               fill_d = FILL_W'(1);
               full_d = 1'b0;
               sop_d  = 1'b0;
            end else begin
               data_d = data_q | placed_fill;
               if (fill_q == FILL_W'(SLOTS-1)) begin
                  full_d = 1'b1;
                  fill_d = '0;
               end else begin
                  fill_d = fill_q + 1'b1;
               end
            end
         end
         if (clear_en && hit) begin
            data_d = '0;
            fill_d = '0;
            full_d = 1'b0;
            sop_d  = 1'b0;
         end
         if (sop_en && (sop_ch == CH_W'(c))) sop_d = 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            data_q <= '0;
            fill_q <= '0;
            full_q <= 1'b0;
            sop_q  <= 1'b0;
         end else begin
            data_q <= data_d;
            fill_q <= fill_d;
            full_q <= full_d;
            sop_q  <= sop_d;
         end
      end

      assign data_arr[c] = data_q;
      assign fill_arr[c] = fill_q;
      assign full_arr[c] = full_q;
      assign sop_arr[c]  = sop_q;
   end

   assign sel_data = data_arr[sel_ch];
   assign sel_fill = fill_arr[sel_ch];
   assign sel_full = full_arr[sel_ch];
   assign sel_sop  = sop_arr[sel_ch];

endmodule

// File: rtl/pkt_sop_gap.sv
`timescale 1ns/1ps
module pkt_sop_gap #(
   parameter int MIN_GAP = 8
)(
   input  logic clk,
   input  logic rst_n,
   input  logic word_en,
   input  logic sop_en,
   output logic err_q
);

   localparam int CNT_W = $clog2(MIN_GAP);
   localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MIN_GAP-1);

   logic [CNT_W-1:0] since_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since_q <= LIMIT;
         err_q   <= 1'b0;
      end else begin
         err_q <= sop_en && (since_q < LIMIT);
         if (sop_en)                           since_q <= '0;
         else if (word_en && since_q != LIMIT) since_q <= since_q + 1'b1;
      end
   end

endmodule

// File: rtl/pkt_word_packer.sv
`timescale 1ns/1ps
module pkt_word_packer
   import pkt_pack_pkg::*;
#(
   parameter int NUM_CH      = 4,
   parameter int SLOTS       = 4,
   parameter int MIN_SOP_GAP = 8,
   parameter bit MSB_FIRST   = 1'b1
)(
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          in_valid,
   input  logic                          in_ctl,
   input  logic [15:0]                   in_word,
   output logic                          out_valid,
   output logic [16*SLOTS-1:0]           out_data,
   output logic [$clog2(NUM_CH)-1:0]     out_chan,
   output logic                          out_sop,
   output logic                          out_eop,
   output logic [$clog2(2*SLOTS)-1:0]    out_mod,
   output logic                          out_abort,
   output logic                          out_buserr
);

   localparam int CH_W   = $clog2(NUM_CH);
   localparam int FILL_W = $clog2(SLOTS);
   localparam int CNT_W  = FILL_W + 1;
   localparam int MOD_W  = $clog2(2*SLOTS);
   localparam int OUT_W  = WORD_W * SLOTS;

   if (NUM_CH < 2 || (NUM_CH & (NUM_CH-1)) != 0 || CH_W > ADDR_W) begin : g_bad_ch
      $error("NUM_CH must be a power of two between 2 and 256");
   end
   if (SLOTS < 2 || (SLOTS & (SLOTS-1)) != 0) begin : g_bad_slots
      $error("SLOTS must be a power of two of at least 2");
   end
   if (MIN_SOP_GAP < 2) begin : g_bad_gap
      $error("MIN_SOP_GAP must be at least 2");
   end

   ctl_hdr_t          hdr;
   logic              ctl_ev, data_ev, end_ev, open_ev, flush, full_out, emit;
   logic [CH_W-1:0]   cur_ch_q, new_ch;
   logic [OUT_W-1:0]  sel_data;
   logic [FILL_W-1:0] sel_fill;
   logic              sel_full, sel_sop;
   logic [CNT_W-1:0]  words;
   logic [CNT_W:0]    bytes;

   assign hdr     = split_hdr(in_word);
   assign new_ch  = in_word[ADDR_LSB +: CH_W];
   assign ctl_ev  = in_valid && in_ctl;
   assign data_ev = in_valid && !in_ctl;
   assign end_ev  = ctl_ev && (hdr.end_kind != END_NONE);
   assign open_ev = ctl_ev && hdr.payload && hdr.sop;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    cur_ch_q <= '0;
      else if (ctl_ev && hdr.payload) cur_ch_q <= new_ch;
   end

   pkt_lane_store #(
      .NUM_CH   (NUM_CH),
      .SLOTS    (SLOTS),
      .MSB_FIRST(MSB_FIRST)
   ) u_lanes (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel_ch  (cur_ch_q),
      .data_en (data_ev),
      .word    (in_word),
      .clear_en(end_ev),
      .sop_en  (open_ev),
      .sop_ch  (new_ch),
      .sel_data(sel_data),
      .sel_fill(sel_fill),
      .sel_full(sel_full),
      .sel_sop (sel_sop)
   );

   pkt_sop_gap #(.MIN_GAP(MIN_SOP_GAP)) u_gap (
      .clk    (clk),
      .rst_n  (rst_n),
      .word_en(in_valid),
      .sop_en (open_ev),
      .err_q  (out_buserr)
   );

   assign words    = sel_full ? CNT_W'(SLOTS) : {1'b0, sel_fill};
   assign bytes    = {words, 1'b0} - {{CNT_W{1'b0}}, (hdr.end_kind == END_ONE)};
   assign flush    = end_ev && (sel_full || sel_fill != '0);
   assign full_out = data_ev && sel_full;
   assign emit     = flush || full_out;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
         out_chan  <= '0;
         out_sop   <= 1'b0;
         out_eop   <= 1'b0;
         out_mod   <= '0;
         out_abort <= 1'b0;
      end else begin
         out_valid <= emit;
         out_data  <= emit ? sel_data : '0;
         out_chan  <= emit ? cur_ch_q : '0;
         out_sop   <= emit && sel_sop;
         out_eop   <= flush;
         out_mod   <= flush ? bytes[MOD_W-1:0] : '0;
         out_abort <= flush && (hdr.end_kind == END_ABORT);
      end
   end

endmodule

// File: rtl/pkt_word_packer_chk.sv
`timescale 1ns/1ps
module pkt_word_packer_chk #(
   parameter int MOD_W = 3
)(
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             in_ctl,
   input logic [3:0]       ctl_hdr,
   input logic             out_valid,
   input logic             out_sop,
   input logic             out_eop,
   input logic             out_abort,
   input logic [MOD_W-1:0] out_mod,
   input logic             out_buserr
);

   // R7
   sop_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_sop |-> out_valid);

   // R5
   eop_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_eop |-> out_valid);

   // R6
   mod_zero_mid_packet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_eop) |-> (out_mod == '0));

   // R9
   abort_is_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_abort |-> out_eop);

   // R11
   buserr_follows_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_buserr |-> $past(in_valid && in_ctl && ctl_hdr[3] && ctl_hdr[0]));

   // R12
   no_buserr_without_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !(in_ctl && ctl_hdr[3] && ctl_hdr[0])) |=> !out_buserr);

   // R10
   quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ctl && !ctl_hdr[3] && ctl_hdr[2:1] == 2'b00) |=> !out_valid);

   // R14
   idle_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && !out_buserr));

   // R3
   data_never_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_ctl) |=> !out_eop);

endmodule

bind pkt_word_packer pkt_word_packer_chk #(.MOD_W(MOD_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ctl    (in_ctl),
   .ctl_hdr   (in_word[15:12]),
   .out_valid (out_valid),
   .out_sop   (out_sop),
   .out_eop   (out_eop),
   .out_abort (out_abort),
   .out_mod   (out_mod),
   .out_buserr(out_buserr)
);

// File: tb/pkt_word_packer_tb.sv
`timescale 1ns/1ps
module pkt_word_packer_tb;

   localparam int NCH = 4;
   localparam int SL  = 4;
   localparam int GAP = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0, in_ctl = 1'b0;
   logic [15:0] in_word = '0;
   logic        out_valid, out_sop, out_eop, out_abort, out_buserr;
   logic [63:0] out_data;
   logic [1:0]  out_chan;
   logic [2:0]  out_mod;

   always #2.5 clk = ~clk;

   pkt_word_packer u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ctl(in_ctl), .in_word(in_word),
      .out_valid(out_valid), .out_data(out_data), .out_chan(out_chan), .out_sop(out_sop),
      .out_eop(out_eop), .out_mod(out_mod), .out_abort(out_abort), .out_buserr(out_buserr)
   );

   int checks = 0, errors = 0;
   bit done = 1'b0;

   logic [15:0] q [NCH][$];
   bit          sp [NCH];
   int          cur = 0;
   int          since = GAP - 1;

   logic        e_v, e_sop, e_eop, e_ab, e_be;
   logic [63:0] e_d;
   logic [1:0]  e_ch;
   logic [2:0]  e_mod;

   task automatic clear_exp();
      e_v = 0; e_d = '0; e_ch = '0; e_sop = 0; e_eop = 0; e_mod = '0; e_ab = 0; e_be = 0;
   endtask

   task automatic emit(input int ch, input bit eop, input bit ab, input int nbytes);
      e_v = 1; e_ch = 2'(ch); e_sop = sp[ch]; e_eop = eop; e_ab = ab;
      e_mod = 3'(nbytes % 8);
      foreach (q[ch][i]) e_d[63-16*i -: 16] = q[ch][i];
      q[ch].delete();
      sp[ch] = 0;
   endtask

   task automatic model(input bit v, input bit c, input logic [15:0] w);
      bit pay, so;
      logic [1:0] st;
      int ch;
      clear_exp();
      if (!v) return;
      if (!c) begin
         if (q[cur].size() == SL) emit(cur, 0, 0, 0);
         q[cur].push_back(w);
      end else begin
         pay = w[15]; st = w[14:13]; so = w[12]; ch = int'(w[5:4]);
         e_be = pay && so && (since < GAP - 1);
         if (st != 2'b00) begin
            if (q[cur].size() > 0) emit(cur, 1, st == 2'b01, q[cur].size()*2 - (st == 2'b11 ? 1 : 0));
            else sp[cur] = 0;
         end
         if (pay) begin
            cur = ch;
            if (so) sp[ch] = 1;
         end
      end
      if (c && w[15] && w[12]) since = 0;
      else if (since < GAP - 1) since++;
   endtask

   task automatic check(input string tag);
      checks++;
      if (out_valid !== e_v || out_data !== e_d || out_chan !== e_ch || out_sop !== e_sop ||
          out_eop !== e_eop || out_mod !== e_mod || out_abort !== e_ab || out_buserr !== e_be) begin
         errors++;
         $display("FAIL %s: got v=%b ch=%0d sop=%b eop=%b mod=%b abort=%b buserr=%b data=%h; expected v=%b ch=%0d sop=%b eop=%b mod=%b abort=%b buserr=%b data=%h",
                  tag, out_valid, out_chan, out_sop, out_eop, out_mod, out_abort, out_buserr, out_data,
                  e_v, e_ch, e_sop, e_eop, e_mod, e_ab, e_be, e_d);
      end
   endtask

   task automatic step(input bit v, input bit c, input logic [15:0] w, input string tag);
      @(negedge clk);
      in_valid = v; in_ctl = c; in_word = w;
      model(v, c, w);
      @(posedge clk);
      #1;
      check(tag);
   endtask

   task automatic pctl(input logic [1:0] st, input bit so, input int ch, input string tag);
      step(1, 1, {1'b1, st, so, 8'(ch), 4'h0}, tag);
   endtask

   task automatic ictl(input logic [1:0] st, input bit so, input string tag);
      step(1, 1, {1'b0, st, so, 8'h00, 4'h0}, tag);
   endtask

   task automatic dat(input logic [15:0] w, input string tag);
      step(1, 0, w, tag);
   endtask

   task automatic pad(input int n);
      for (int i = 0; i < n; i++) ictl(2'b00, 0, "R10");
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got no completion, expected the sequence to finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      clear_exp();
      repeat (3) @(negedge clk);
      check("R1");
      rst_n = 1'b1;
      ictl(2'b10, 0, "R1");

      // R2 R3 R7: four words on channel 1, full word flushed by end
      pctl(2'b00, 1, 1, "R2");
      dat(16'h1A01, "R3"); dat(16'h1A02, "R3"); dat(16'h1A03, "R3"); dat(16'h1A04, "R3");
      ictl(2'b10, 0, "R7");
      pad(8);

      // R5 R6: short packet, 4 bytes
      pctl(2'b00, 1, 2, "R5");
      dat(16'h2B01, "R5"); dat(16'h2B02, "R5");
      ictl(2'b10, 0, "R6");
      pad(8);

      // R4: interleaved channels 1 and 3, one-byte end on channel 1
      pctl(2'b00, 1, 1, "R4");
      dat(16'h1C01, "R4"); dat(16'h1C02, "R4");
      pad(5);
      pctl(2'b00, 1, 3, "R4");
      dat(16'h3C01, "R4"); dat(16'h3C02, "R4"); dat(16'h3C03, "R4");
      pctl(2'b00, 0, 1, "R4");
      dat(16'h1C03, "R4");
      pctl(2'b11, 0, 3, "R6");
      dat(16'h3C04, "R4");
      ictl(2'b10, 0, "R5");
      pad(8);

      // R3 R6: fifth word pushes out the full word, then a 1-byte end
      pctl(2'b00, 1, 0, "R3");
      for (int i = 0; i < 5; i++) dat(16'h0D00 + 16'(i), "R3");
      ictl(2'b11, 0, "R6");
      pad(8);

      // R8 R10 R11: start exactly at the minimum gap combined with end of previous channel
      pctl(2'b00, 1, 2, "R8");
      ictl(2'b00, 1, "R10");
      dat(16'h2E01, "R8"); dat(16'h2E02, "R8");
      pad(4);
      pctl(2'b10, 1, 3, "R11");
      dat(16'h3E01, "R8"); dat(16'h3E02, "R8");
      ictl(2'b10, 0, "R8");
      pctl(2'b00, 1, 1, "R11");
      dat(16'h1E01, "R11");
      pad(5);
      pctl(2'b00, 1, 0, "R11");
      dat(16'h0E01, "R11");
      ictl(2'b10, 0, "R6");

      // R9: abort on channel 1 after interleaved start
      pctl(2'b00, 0, 1, "R4");
      dat(16'h1E02, "R9");
      ictl(2'b01, 0, "R9");

      // R12: back-to-back non-start payload control words
      pctl(2'b00, 0, 0, "R12"); dat(16'h0F01, "R12");
      pctl(2'b00, 0, 2, "R12"); dat(16'h2F01, "R12");
      pctl(2'b00, 0, 0, "R12"); dat(16'h0F02, "R12");
      pctl(2'b00, 0, 2, "R12"); dat(16'h2F02, "R12");
      ictl(2'b10, 0, "R12");
      pctl(2'b00, 0, 0, "R12");
      ictl(2'b10, 0, "R12");

      // R13: ends on empty channels
      ictl(2'b10, 0, "R13");
      pctl(2'b11, 0, 3, "R13");
      pad(8);

      // R14: invalid cycles leave state untouched
      pctl(2'b00, 1, 1, "R14");
      dat(16'h1F0A, "R14");
      step(0, 0, 16'hDEAD, "R14");
      step(0, 1, {1'b1, 2'b10, 1'b1, 8'h02, 4'h0}, "R14");
      dat(16'h1F0B, "R14");
      ictl(2'b10, 0, "R14");

      pad(2);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule